// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Controller

This block sits beside a small 8-bit processor core and decides when the core leaves its program flow to serve an interrupt. Two sources feed it: a USB event line and a timer overflow line. Each source sets its own request flag. The flags, one enable per source and a global enable all live in a single 8-bit control register. The core reads and writes that register through a plain data-memory port.

Once per instruction cycle the core pulses a T2 timing strobe. At that edge the block checks the register. A request is taken when the global enable is on, the source enable is on, the flag is set and the core's return stack still has room. When that holds, the block pulses an acknowledge for one cycle and presents the vector address. In the same edge it clears the flag it served and the global enable. A return-from-interrupt turns the global enable back on. A plain return does not.

Top module: `dual_irq_vectoring`

## Requirements
- R1: After reset the control register reads 0x00, `irq_ack` is 0 and `irq_vector` is 0x00.
- R2: The control register answers only at data address 0x0B. Its layout is: bit 0 global enable, bit 1 USB enable, bit 2 timer enable, bit 4 USB request flag, bit 6 timer request flag. Bits 3, 5 and 7 read as 0. A read at any other address returns 0x00, and a write to any other address leaves the register unchanged.
- R3: A `usb_event` pulse sets bit 4 and a `timer_ovf` pulse sets bit 6. A flag stays set until its interrupt is served or software writes it to 0.
- R4: A software write that sets a request flag makes a request exactly like a hardware event.
- R5: A dispatch happens only at a clock edge where `t2_strobe` is 1, the global enable is 1, `stack_full` is 0, and at least one source has both its enable and its flag set. `irq_ack` is 1 in the cycle after that edge and 0 otherwise.
- R6: The vector is 0x04 for a USB dispatch and 0x0C for a timer dispatch. `irq_vector` keeps its last value between dispatches.
- R7: If both sources are ready at the same strobe, USB is served and the timer flag stays set.
- R8: On dispatch the served flag and the global enable are cleared. The other flag and both source enables are unchanged.
- R9: `reti_exec` sets the global enable. `ret_exec` leaves the register unchanged.
- R10: A request raised between strobes waits. It is dispatched at the next strobe edge and never at an edge without a strobe.
- R11: If several updates land in one cycle, the register takes them in this order: the software write, then `reti_exec`, then the dispatch clear, then the hardware event sets. So a hardware event is never lost, and a dispatch clears a global enable that `reti_exec` sets in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| t2_strobe | input | 1 | Once-per-instruction sampling strobe |
| usb_event | input | 1 | USB event pulse, sets the USB flag |
| timer_ovf | input | 1 | Timer overflow pulse, sets the timer flag |
| stack_full | input | 1 | The core's return stack has no free entry |
| ret_exec | input | 1 | Core executes a plain return |
| reti_exec | input | 1 | Core executes a return-from-interrupt |
| reg_addr | input | 8 | Data-memory address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| irq_ack | output | 1 | One-cycle interrupt acknowledge |
| irq_vector | output | 8 | Vector address of the last dispatch |

## Verification
The directed cases each change one condition at a time:
- a single USB request;
- a single timer request;
- both requests ready together;
- a request held back first by the global enable and then by a full stack;
- a request raised off-strobe.

Side by side, these show the priority order and the gating terms apart. Further directed cases cover RET against RETI, a write to a foreign address and a request made by a software write. A long run of seeded random cycles then mixes events, writes, returns, strobes and stack state in the same cycle. That run exposes the ordering of same-cycle updates, and a bench model built from the requirements predicts every cycle.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  localparam int unsigned CTL_W = 8;
  localparam int unsigned B_MST = 0;
  localparam int unsigned B_UEN = 1;
  localparam int unsigned B_TEN = 2;
  localparam int unsigned B_UFL = 4;
  localparam int unsigned B_TFL = 6;

  typedef struct packed {
    logic mst;
    logic uen;
    logic ten;
    logic ufl;
    logic tfl;
  } ctl_t;

  function automatic logic [CTL_W-1:0] ctl_to_bits(ctl_t c);
    logic [CTL_W-1:0] b;
    b = '0;
    b[B_MST] = c.mst;
    b[B_UEN] = c.uen;
    b[B_TEN] = c.ten;
    b[B_UFL] = c.ufl;
    b[B_TFL] = c.tfl;
    return b;
  endfunction

  function automatic ctl_t bits_to_ctl(logic [CTL_W-1:0] b);
    ctl_t c;
    c.mst = b[B_MST];
    c.uen = b[B_UEN];
    c.ten = b[B_TEN];
    c.ufl = b[B_UFL];
    c.tfl = b[B_TFL];
    return c;
  endfunction

  function automatic logic usb_ready(ctl_t c);
    return c.uen & c.ufl;
  endfunction

  function automatic logic tmr_ready(ctl_t c);
    return c.ten & c.tfl;
  endfunction
endpackage

// File: rtl/dirq_ctl_reg.sv
module dirq_ctl_reg
  import dirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wdata,
  input  logic             ret_in,
  input  logic             reti_in,
  input  logic             disp,
  input  logic             disp_usb,
  input  logic             set_usb,
  input  logic             set_tmr,
  output ctl_t             ctl_q
);
  ctl_t ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) ctl_d = bits_to_ctl(wdata);
    if (reti_in) ctl_d.mst = 1'b1;
    if (disp) begin
      ctl_d.mst = 1'b0;
      if (disp_usb) ctl_d.ufl = 1'b0;
      else          ctl_d.tfl = 1'b0;
    end
    if (set_usb) ctl_d.ufl = 1'b1;
    if (set_tmr) ctl_d.tfl = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  // R9
  reti_sets_mst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_in && !disp) |=> ctl_q.mst);
  // R9
  ret_keeps_mst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_in && !reti_in && !wr_en && !disp) |=> $stable(ctl_q.mst));
  // R3
  usb_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !disp && !set_usb) |=> $stable(ctl_q.ufl));
  // R11
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_tmr) |=> ctl_q.tfl);
endmodule

// File: rtl/dirq_select.sv
module dirq_select
  import dirq_pkg::*;
#(
  parameter int unsigned         VEC_W   = 8,
  parameter logic [VEC_W-1:0]    USB_VEC = 8'h04,
  parameter logic [VEC_W-1:0]    TMR_VEC = 8'h0C
)(
  input  ctl_t             ctl,
  input  logic             strobe,
  input  logic             stack_full,
  output logic             disp,
  output logic             disp_usb,
  output logic [VEC_W-1:0] vec
);
  logic any_ready;

  always_comb begin
    any_ready = usb_ready(ctl) | tmr_ready(ctl);
    disp      = strobe & ctl.mst & ~stack_full & any_ready;
    disp_usb  = usb_ready(ctl);
    vec       = disp_usb ? USB_VEC : TMR_VEC;
  end
endmodule

// File: rtl/dual_irq_vectoring.sv
module dual_irq_vectoring
  import dirq_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0]    CTL_ADDR = 8'h0B,
  parameter int unsigned          VEC_W    = 8,
  parameter logic [VEC_W-1:0]     USB_VEC  = 8'h04,
  parameter logic [VEC_W-1:0]     TMR_VEC  = 8'h0C
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              t2_strobe,
  input  logic              usb_event,
  input  logic              timer_ovf,
  input  logic              stack_full,
  input  logic              ret_exec,
  input  logic              reti_exec,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [CTL_W-1:0]  reg_wdata,
  output logic [CTL_W-1:0]  reg_rdata,
  output logic              irq_ack,
  output logic [VEC_W-1:0]  irq_vector
);
  ctl_t             ctl_q;
  logic             sel_hit;
  logic             disp;
  logic             disp_usb;
  logic [VEC_W-1:0] sel_vec;

  assign sel_hit   = (reg_addr == CTL_ADDR);
  assign reg_rdata = sel_hit ? ctl_to_bits(ctl_q) : '0;

  dirq_ctl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr & sel_hit),
    .wdata    (reg_wdata),
    .ret_in   (ret_exec),
    .reti_in  (reti_exec),
    .disp     (disp),
    .disp_usb (disp_usb),
    .set_usb  (usb_event),
    .set_tmr  (timer_ovf),
    .ctl_q    (ctl_q)
  );

  dirq_select #(
    .VEC_W   (VEC_W),
    .USB_VEC (USB_VEC),
    .TMR_VEC (TMR_VEC)
  ) u_sel (
    .ctl        (ctl_q),
    .strobe     (t2_strobe),
    .stack_full (stack_full),
    .disp       (disp),
    .disp_usb   (disp_usb),
    .vec        (sel_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_ack    <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_ack <= disp;
      if (disp) irq_vector <= sel_vec;
    end
  end

  // R5
  ack_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> ($past(t2_strobe) && $past(ctl_q.mst) && !$past(stack_full)));
  // R8
  ack_clears_mst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> !ctl_q.mst);
  // R7
  usb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && $past(ctl_q.uen && ctl_q.ufl)) |-> (irq_vector == USB_VEC));
  // R6
  vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (irq_vector == USB_VEC || irq_vector == TMR_VEC));
  // R6
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_ack |-> $stable(irq_vector));
endmodule

// File: tb/dual_irq_vectoring_test.sv
module dual_irq_vectoring_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       t2_strobe = 0, usb_event = 0, timer_ovf = 0, stack_full = 0;
  logic       ret_exec = 0, reti_exec = 0, reg_wr = 0;
  logic [7:0] reg_addr = 8'h0B, reg_wdata = 8'h00;
  logic [7:0] reg_rdata, irq_vector;
  logic       irq_ack;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] m_reg;
  logic [7:0] m_vec;
  logic       m_ack;

  always #2 clk = ~clk;

  dual_irq_vectoring uut (
    .clk(clk), .rst_n(rst_n), .t2_strobe(t2_strobe), .usb_event(usb_event),
    .timer_ovf(timer_ovf), .stack_full(stack_full), .ret_exec(ret_exec),
    .reti_exec(reti_exec), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
    .irq_vector(irq_vector)
  );

  function automatic logic [7:0] legal(logic [7:0] v);
    return v & 8'b0101_0111;
  endfunction

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one cycle: drive after the falling edge, predict, sample 1 ns after the rising edge
  task automatic step(string tag, logic strb, logic ue, logic te, logic stk,
                      logic rt, logic rti, logic wr, logic [7:0] addr, logic [7:0] wd);
    logic hit, uok, tok, go, pick;
    logic [7:0] base;
    @(negedge clk);
    t2_strobe = strb; usb_event = ue; timer_ovf = te; stack_full = stk;
    ret_exec = rt; reti_exec = rti; reg_wr = wr; reg_addr = addr; reg_wdata = wd;
    hit  = (addr == 8'h0B);
    uok  = m_reg[1] & m_reg[4];
    tok  = m_reg[2] & m_reg[6];
    go   = strb & m_reg[0] & !stk & (uok | tok);
    pick = uok;
    base = (wr && hit) ? legal(wd) : m_reg;
    base[0] = base[0] | rti;
    if (go) begin
      base[0] = 1'b0;
      if (pick) base[4] = 1'b0; else base[6] = 1'b0;
    end
    base[4] = base[4] | ue;
    base[6] = base[6] | te;
    m_reg = base;
    m_ack = go;
    if (go) m_vec = pick ? 8'h04 : 8'h0C;
    @(posedge clk);
    #1;
    check8({tag, " ack"}, {7'd0, irq_ack}, {7'd0, m_ack});
    check8({tag, " vector"}, irq_vector, m_vec);
    check8({tag, " rdata"}, reg_rdata, hit ? m_reg : 8'h00);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 8'h0B, 8'h00);
  endtask

  task automatic wreg(string tag, logic [7:0] v);
    step(tag, 0, 0, 0, 0, 0, 0, 1, 8'h0B, v);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_reg = 8'h00; m_vec = 8'h00; m_ack = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check8("R1 rdata", reg_rdata, 8'h00);
    check8("R1 ack", {7'd0, irq_ack}, 8'h00);
    check8("R1 vector", irq_vector, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 layout: unused bits read 0, foreign address reads 0 and ignores writes
    wreg("R2 write all ones", 8'hFF);
    check8("R2 layout", reg_rdata, 8'h57);
    step("R2 foreign write", 0, 0, 0, 0, 0, 0, 1, 8'h0A, 8'h00);
    check8("R2 foreign read", reg_rdata, 8'h00);
    idle("R2 readback");
    check8("R2 unchanged", reg_rdata, 8'h57);
    wreg("R2 clear", 8'h00);

    // R3 USB event sets bit 4 and holds; R10 no dispatch without strobe
    wreg("R3 enables", 8'h07);
    step("R3 usb event", 0, 1, 0, 0, 0, 0, 0, 8'h0B, 8'h00);
    check8("R3 usb flag", reg_rdata, 8'h17);
    idle("R10 wait");
    check8("R10 no ack off strobe", {7'd0, irq_ack}, 8'h00);
    // R5 R6 dispatch at strobe, vector 0x04; R8 clears flag and master
    step("R5 strobe", 1, 0, 0, 0, 0, 0, 0, 8'h0B, 8'h00);
    check8("R5 ack", {7'd0, irq_ack}, 8'h01);
    check8("R6 usb vector", irq_vector, 8'h04);
    check8("R8 after usb", reg_rdata, 8'h06);
    idle("R5 one cycle");
    check8("R5 ack drops", {7'd0, irq_ack}, 8'h00);

    // R9 RET keeps master off, RETI sets it
    step("R9 ret", 0, 0, 0, 0, 1, 0, 0, 8'h0B, 8'h00);
    check8("R9 ret no change", reg_rdata, 8'h06);
    step("R9 reti", 0, 0, 0, 0, 0, 1, 0, 8'h0B, 8'h00);
    check8("R9 reti sets master", reg_rdata, 8'h07);

    // R7 both ready: USB served, timer flag kept
    step("R7 both events", 0, 1, 1, 0, 0, 0, 0, 8'h0B, 8'h00);
    step("R7 strobe", 1, 0, 0, 0, 0, 0, 0, 8'h0B, 8'h00);
    check8("R7 vector usb", irq_vector, 8'h04);
    check8("R7 timer kept", reg_rdata, 8'h46);
    // R5 master off blocks
    step("R5 master off", 1, 0, 0, 0, 0, 0, 0, 8'h0B, 8'h00);
    check8("R5 no ack master off", {7'd0, irq_ack}, 8'h00);
    step("R9 reti again", 0, 0, 0, 0, 0, 1, 0, 8'h0B, 8'h00);
    // R5 full stack blocks
    step("R5 stack full", 1, 0, 0, 1, 0, 0, 0, 8'h0B, 8'h00);
    check8("R5 no ack stack full", {7'd0, irq_ack}, 8'h00);
    step("R6 timer strobe", 1, 0, 0, 0, 0, 0, 0, 8'h0B, 8'h00);
    check8("R6 timer vector", irq_vector, 8'h0C);
    check8("R8 after timer", reg_rdata, 8'h06);

    // R4 software-set flag requests
    wreg("R4 sw set timer", 8'h47);
    step("R4 strobe", 1, 0, 0, 0, 0, 0, 0, 8'h0B, 8'h00);
    check8("R4 ack", {7'd0, irq_ack}, 8'h01);
    check8("R4 vector", irq_vector, 8'h0C);

    // R11 event same cycle as sw clear survives
    step("R11 write vs event", 0, 1, 0, 0, 0, 0, 1, 8'h0B, 8'h00);
    check8("R11 event wins", reg_rdata, 8'h10);

    // random phase against the bench model
    for (int i = 0; i < 4000; i++) begin
      logic wr;
      logic [7:0] a;
      wr = ($urandom % 10) == 0;
      a  = (($urandom % 8) == 0) ? 8'($urandom) : 8'h0B;
      step("R3 R5 R7 R8 R11 random",
           ($urandom % 4) == 0, ($urandom % 10) == 0, ($urandom % 10) == 0,
           ($urandom % 5) == 0, ($urandom % 20) == 0, ($urandom % 12) == 0,
           wr, a, 8'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule